// File: doc/BRIEF.md
# Runtime-Formatted Asynchronous Serial Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single transmit line. Each frame uses the format present on the configuration inputs when the start strobe is taken. The payload can be 5 to 8 bits long. The parity slot can be odd, even, forced high, forced low or absent. The trailing high period can last half a bit, one bit, one and a half bits or two bits.

All timing comes from a divider that produces one tick per half bit time. The clock frequency and the baud rate are parameters, so a rate agreed with the far end (for example 9600 or 115200) is fixed at build time. A host puts the word and the format on the inputs, pulses the strobe while the busy flag is low, and then waits for busy to drop before it sends the next word.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `txd_o` is 1 and `busy_o` is 0.
- R2: A `start_i` high in a cycle where `busy_o` is 0 is accepted at the next clock edge. From that edge `busy_o` is 1 and `txd_o` is 0 for one bit time (the start bit).
- R3: The payload follows the start bit, least significant bit first, one bit time per bit. Its length is `len_i` + 5 (code 0 gives 5 bits and code 3 gives 8 bits).
- R4: With `par_i` = 1 (odd) or 2 (even), one parity bit follows the payload. It makes the count of ones across the payload and the parity bit odd or even, as selected.
- R5: With `par_i` = 3 the parity slot is always 1. With `par_i` = 4 it is always 0. With `par_i` = 0, 5, 6 or 7 the slot is left out and the stop period follows the payload directly.
- R6: The stop period drives `txd_o` high for (`stop_i` + 1) half bit times, which gives 0.5, 1, 1.5 or 2 bits. `busy_o` falls at the edge where that period ends.
- R7: Data and format are captured when the strobe is accepted. Changes on `data_i`, `len_i`, `par_i`, `stop_i` and any `start_i` pulses while `busy_o` is 1 have no effect on the frame in progress.
- R8: A strobe given in the first cycle in which `busy_o` is low starts the next start bit at the following edge.
- R9: One half bit time lasts CLK_HZ / (2 × BAUD) clock cycles, and every bit edge of a frame falls on a whole multiple of that count after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Send strobe |
| data_i | input | 8 | Word to send; bits above the payload length are ignored |
| len_i | input | 2 | Payload length code (length = code + 5) |
| par_i | input | 3 | Parity mode: 0 none, 1 odd, 2 even, 3 mark, 4 space, 5 to 7 none |
| stop_i | input | 2 | Stop length in half bits, minus one |
| busy_o | output | 1 | Frame in progress |
| txd_o | output | 1 | Serial output, idles high |

## Verification
Two functions can fall in the same cycle: the end of one frame's stop period and the acceptance of the next strobe. The bench chains its frames so that each new strobe is raised in the very first cycle in which busy reads low, and it checks that the next start bit begins on the following edge with no extra idle time. The second collision is a new strobe arriving in the middle of a frame. During most frames the bench pulses the strobe at random and changes every configuration input, and the whole waveform of the frame in progress must still match the levels computed from the format that was captured.

// File: rtl/cfg_uart_tx_pkg.sv
package cfg_uart_tx_pkg;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } tx_phase_e;

    typedef struct packed {
        tx_phase_e   st;
        logic [7:0]  shreg;
        logic [2:0]  bits_left;
        logic [2:0]  halves;
        logic [1:0]  stop;
        logic        par_en;
        logic        par_bit;
        logic        txd;
        logic        busy;
    } tx_state_t;

endpackage

// File: rtl/cfg_uart_tx_halftick.sv
module cfg_uart_tx_halftick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    generate
        if (HALF_CYC <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clr_i || cnt_q == LAST) cnt_d = '0;
                else                        cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);

            // R9: ticks are separated by HALF_CYC cycles, never adjacent
            a_r9_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/cfg_uart_tx_parity.sv
module cfg_uart_tx_parity
    import cfg_uart_tx_pkg::*;
(
    input  logic [7:0] data_i,
    input  logic [1:0] len_i,
    input  logic [2:0] mode_i,
    output logic       en_o,
    output logic       bit_o
);
    logic ones_odd;

    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 32'(len_i) + 5) ones_odd = ones_odd ^ data_i[i];
        end
    end

    always_comb begin
        en_o  = 1'b1;
        bit_o = 1'b0;
        case (mode_i)
            PAR_ODD:   bit_o = ~ones_odd;
            PAR_EVEN:  bit_o = ones_odd;
            PAR_MARK:  bit_o = 1'b1;
            PAR_SPACE: bit_o = 1'b0;
            default:   en_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
    import cfg_uart_tx_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [7:0] data_i,
    input  logic [1:0] len_i,
    input  logic [2:0] par_i,
    input  logic [1:0] stop_i,
    output logic       busy_o,
    output logic       txd_o
);
    localparam int HALF_RAW = CLK_HZ / (2 * BAUD);
    localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

    localparam tx_state_t RST_VAL = '{
        st: PH_IDLE, shreg: '0, bits_left: '0, halves: '0, stop: '0,
        par_en: 1'b0, par_bit: 1'b0, txd: 1'b1, busy: 1'b0
    };

    tx_state_t q, d;
    logic      accept, tick, par_en, par_bit, last_tick;

    assign accept = start_i && !q.busy;

    cfg_uart_tx_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (accept),
        .tick_o (tick)
    );

    cfg_uart_tx_parity u_par (
        .data_i (data_i),
        .len_i  (len_i),
        .mode_i (par_i),
        .en_o   (par_en),
        .bit_o  (par_bit)
    );

    assign last_tick = (q.st == PH_STOP) && (q.halves == 3'd1) && tick;

    always_comb begin
        d = q;
        if (accept) begin
            d.busy      = 1'b1;
            d.st        = PH_START;
            d.shreg     = data_i;
            d.bits_left = {1'b0, len_i} + 3'd4;
            d.stop      = stop_i;
            d.par_en    = par_en;
            d.par_bit   = par_bit;
            d.txd       = 1'b0;
            d.halves    = 3'd2;
        end else if (q.busy && tick) begin
            if (q.halves != 3'd1) begin
                d.halves = q.halves - 3'd1;
            end else begin
                d.halves = 3'd2;
                case (q.st)
                    PH_START: begin
                        d.st  = PH_DATA;
                        d.txd = q.shreg[0];
                    end
                    PH_DATA: begin
                        if (q.bits_left != 3'd0) begin
                            d.shreg     = q.shreg >> 1;
                            d.txd       = q.shreg[1];
                            d.bits_left = q.bits_left - 3'd1;
                        end else if (q.par_en) begin
                            d.st  = PH_PAR;
                            d.txd = q.par_bit;
                        end else begin
                            d.st     = PH_STOP;
                            d.txd    = 1'b1;
                            d.halves = {1'b0, q.stop} + 3'd1;
                        end
                    end
                    PH_PAR: begin
                        d.st     = PH_STOP;
                        d.txd    = 1'b1;
                        d.halves = {1'b0, q.stop} + 3'd1;
                    end
                    default: begin
                        d.st   = PH_IDLE;
                        d.busy = 1'b0;
                        d.txd  = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d;
    end

    assign busy_o = q.busy;
    assign txd_o  = q.txd;

    // R1: an idle line is high
    a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> txd_o);

    // R2: an accepted strobe opens a low start bit on the next cycle
    a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && !txd_o));

    // R6: the stop period is always high
    a_r6_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == PH_STOP) |-> txd_o);

    // R5: the parity slot exists only for modes that carry one
    a_r5_par_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == PH_PAR) |-> q.par_en);

    // R7: captured format stays fixed for the whole frame
    a_r7_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !last_tick) |=> ($stable(q.stop) && $stable(q.par_en) && $stable(q.par_bit)));
endmodule

// File: tb/cfg_uart_tx_tb_top.sv
module cfg_uart_tx_tb_top;
    localparam int CLK_HZ = 8;
    localparam int BAUD   = 1;
    localparam int HALF   = CLK_HZ / (2 * BAUD);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] data = '0;
    logic [1:0] len = '0;
    logic [2:0] par = '0;
    logic [1:0] stop = '0;
    logic       busy, txd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cfg_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
        .len_i(len), .par_i(par), .stop_i(stop), .busy_o(busy), .txd_o(txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input int ln, input int pm,
                             input int sp, input bit noise);
        logic lvl [0:31];
        int   nh = 0;
        int   nb = ln + 5;
        int   ones = 0;
        bit   bad = 1'b0;
        int   bad_c = 0;
        int   act_v = 0;
        int   exp_v = 0;
        for (int k = 0; k < 2; k++) begin lvl[nh] = 1'b0; nh++; end
        for (int b = 0; b < nb; b++) begin
            ones += int'(d[b]);
            for (int k = 0; k < 2; k++) begin lvl[nh] = d[b]; nh++; end
        end
        if (pm >= 1 && pm <= 4) begin
            logic pb;
            case (pm)
                1: pb = (ones % 2 == 0);
                2: pb = (ones % 2 == 1);
                3: pb = 1'b1;
                default: pb = 1'b0;
            endcase
            for (int k = 0; k < 2; k++) begin lvl[nh] = pb; nh++; end
        end
        for (int k = 0; k <= sp; k++) begin lvl[nh] = 1'b1; nh++; end

        data = d; len = 2'(ln); par = 3'(pm); stop = 2'(sp); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < nh * HALF; c++) begin
            if (!bad && (txd !== lvl[c / HALF] || busy !== 1'b1)) begin
                bad = 1'b1; bad_c = c;
                act_v = {busy, txd}; exp_v = {1'b1, lvl[c / HALF]};
            end
            if (noise) begin
                data  = 8'($urandom);
                len   = 2'($urandom);
                par   = 3'($urandom);
                stop  = 2'($urandom);
                start = (c < nh * HALF - 1) ? 1'($urandom) : 1'b0;
            end
            @(negedge clk);
        end
        if (bad) $display("  frame len=%0d par=%0d stop=%0d data=%h diverged at cycle %0d",
                          ln, pm, sp, d, bad_c);
        // R2 start bit, R3 payload, R4/R5 parity slot, R7 noise ignored, R9 half-bit grid
        check(!bad, "R2 R3 R4 R5 R7 R9 waveform {busy,txd}", act_v, exp_v);
        // R6: busy falls exactly when the stop period ends; R8 readiness in that cycle
        check(busy === 1'b0 && txd === 1'b1, "R6 R8 end of frame {busy,txd}",
              {busy, txd}, 1);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(txd === 1'b1 && busy === 1'b0, "R1 reset {busy,txd}", {busy, txd}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R1 after reset {busy,txd}", {busy, txd}, 1);
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 8; pm++) begin
                for (int sp = 0; sp < 4; sp++) begin
                    // R8: consecutive frames are strobed in the first idle cycle
                    run_frame(8'($urandom), ln, pm, sp, ((pm + sp) % 2) == 1);
                    run_frame(8'h5A ^ 8'(pm * 17 + sp), ln, pm, sp, 1'b1);
                    if (sp == 3) begin
                        for (int g = 0; g < 3; g++) begin
                            @(negedge clk);
                            check(txd === 1'b1 && busy === 1'b0, "R1 idle gap {busy,txd}",
                                  {busy, txd}, 1);
                        end
                    end
                end
            end
        end
        // R3 corner words: all ones and all zeros at each length
        for (int ln = 0; ln < 4; ln++) begin
            run_frame(8'hFF, ln, 1, 1, 1'b0);
            run_frame(8'h00, ln, 2, 0, 1'b0);
        end
        done = 1'b1;
        report();
    end
endmodule